// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block checks whether its own clock runs at the expected rate. It counts cycles of that clock between successive chosen edges of an asynchronous reference input. At each closing edge it stores the count and compares it with a software-programmed lower and upper limit. A count inside the inclusive window marks a finished measurement. A count outside the window also raises a sticky frequency-error flag. Two interrupt outputs follow the flags, and each has its own enable.

Software drives plain control pins. It sets the limits, the edge choice, the reference-mode and reference-pin enables, and a write strobe for the run bit. It also drives one-cycle clear strobes for each flag. The block has no streaming data path, so it has no valid/ready pair and no back-pressure. The capture register is overwritten on every closing edge, whether or not software has read the previous value. After the run bit is set, the first valid edge only starts the counter. Every later edge closes one period and opens the next one.

Top module: `clk_window_monitor`

## Requirements
- R1: After reset, `meas_count` is 0, and `run_active`, `end_flag`, `err_flag`, `irq_end` and `irq_err` are all 0.
- R2: A write (`run_wr`=1) with `run_wdata`=1 turns measurement on only when `ref_mode_pin` and `ref_pin_en` are both 1. Otherwise `run_active` stays 0, and reference edges change neither `meas_count` nor `end_flag`.
- R3: The first valid reference edge after measurement is turned on only starts the counter. `meas_count` and both flags stay unchanged.
- R4: Each later valid edge loads `meas_count` with the number of clock cycles since the previous valid edge, and counting restarts from zero on that same edge.
- R5: A captured count that is at least `lim_lower` and at most `lim_upper` sets `end_flag` and leaves `err_flag` unchanged. Both limits are inclusive.
- R6: A captured count greater than `lim_upper` sets both `err_flag` and `end_flag`.
- R7: A captured count less than `lim_lower` sets both `err_flag` and `end_flag`.
- R8: `edge_sel` picks the valid edge: 2'b00 rising, 2'b01 falling, 2'b10 both edges, and 2'b11 rising.
- R9: A one-cycle pulse on `clr_end` clears `end_flag`, and a pulse on `clr_err` clears `err_flag`. Neither pulse touches the other flag. A flag being set in the same cycle takes priority over its clear.
- R10: `irq_end` is high exactly while `end_flag` and `irq_end_en` are both 1. `irq_err` is high exactly while `err_flag` and `irq_err_en` are both 1.
- R11: Writing 0 to the run bit sets `run_active` to 0, clears the counter and stops it, so later edges do not capture. After measurement is turned on again, the first edge only starts the counter.
- R12: The counter saturates at all ones and does not wrap. A reference period longer than the counter can hold is captured as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Asynchronous reference signal |
| ref_mode_pin | input | 1 | 1 selects the pin-reference mode |
| ref_pin_en | input | 1 | 1 enables the reference pin |
| edge_sel | input | 2 | Valid-edge choice (see R8) |
| lim_upper | input | CNT_W | Upper limit, inclusive |
| lim_lower | input | CNT_W | Lower limit, inclusive |
| run_wr | input | 1 | Write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| irq_end_en | input | 1 | Enable for the measurement-end interrupt |
| irq_err_en | input | 1 | Enable for the frequency-error interrupt |
| clr_end | input | 1 | Write-one-to-clear pulse for `end_flag` |
| clr_err | input | 1 | Write-one-to-clear pulse for `err_flag` |
| meas_count | output | CNT_W | Last captured period count |
| run_active | output | 1 | Measurement is turned on |
| end_flag | output | 1 | Sticky measurement-end flag |
| err_flag | output | 1 | Sticky frequency-error flag |
| irq_end | output | 1 | Measurement-end interrupt |
| irq_err | output | 1 | Frequency-error interrupt |

## Verification
The bench builds the block with CNT_W=8 and the default two-stage synchronizer. With an 8-bit counter, the saturation case of R12 takes a 300-cycle reference period instead of one longer than 65,535 cycles. With limits of 50 and 100, both window edges, both out-of-window sides, asymmetric high and low phases for each edge mode, and stopping and rearming all fit into short directed scenarios. The reference is driven on falling clock edges, so the spacing between detected edges equals the spacing of the stimulus whatever the synchronizer latency.

// File: rtl/clk_window_pkg.sv
`timescale 1ns/1ps
package clk_window_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'b00,
    VERDICT_INSIDE = 2'b01,
    VERDICT_OUTSIDE = 2'b10
  } verdict_e;

endpackage

// File: rtl/ref_edge_detect.sv
`timescale 1ns/1ps
module ref_edge_detect
  import clk_window_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_async,
  input  logic [1:0] edge_sel,
  output logic       edge_pulse
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise_w;
  logic                   fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= ref_async;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_w = sync_q[LAST] & ~prev_q;
  assign fall_w = ~sync_q[LAST] & prev_q;

  always_comb begin
    unique case (edge_mode_e'(edge_sel))
      EDGE_FALL: edge_pulse = fall_w;
      EDGE_BOTH: edge_pulse = rise_w | fall_w;
      default:   edge_pulse = rise_w;
    endcase
  end

  // R8
  single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel != 2'b10 && edge_pulse) |=> !edge_pulse);

endmodule

// File: rtl/period_counter.sv
`timescale 1ns/1ps
module period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             edge_pulse,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             armed_q;

  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_ZERO;
      armed_q   <= 1'b0;
      cap_value <= CNT_ZERO;
      cap_valid <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (!run) begin
        cnt_q   <= CNT_ZERO;
        armed_q <= 1'b0;
      end else if (edge_pulse) begin
        cnt_q <= CNT_ZERO;
        if (!armed_q) begin
          armed_q <= 1'b1;
        end else begin
          cap_value <= cnt_inc;
          cap_valid <= 1'b1;
        end
      end else if (armed_q) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  // R3
  arm_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !armed_q && edge_pulse) |=> (!cap_valid && $stable(cap_value)));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed_q && edge_pulse) |=> (cap_valid && cnt_q == CNT_ZERO));

  // R11
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt_q == CNT_ZERO && !cap_valid));

  // R12
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed_q && !edge_pulse && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/window_check.sv
`timescale 1ns/1ps
module window_check
  import clk_window_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cap_value,
  input  logic             cap_valid,
  input  logic [CNT_W-1:0] lim_upper,
  input  logic [CNT_W-1:0] lim_lower,
  input  logic             clr_end,
  input  logic             clr_err,
  output logic             end_flag,
  output logic             err_flag
);

  verdict_e verdict;

  always_comb begin
    if (!cap_valid)
      verdict = VERDICT_NONE;
    else if (cap_value > lim_upper || cap_value < lim_lower)
      verdict = VERDICT_OUTSIDE;
    else
      verdict = VERDICT_INSIDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (verdict != VERDICT_NONE) end_flag <= 1'b1;
      else if (clr_end)            end_flag <= 1'b0;
      if (verdict == VERDICT_OUTSIDE) err_flag <= 1'b1;
      else if (clr_err)               err_flag <= 1'b0;
    end
  end

  // R6
  above_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_value > lim_upper) |=> (err_flag && end_flag));

  // R7
  below_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_value < lim_lower) |=> (err_flag && end_flag));

  // R5
  inside_keeps_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_value <= lim_upper && cap_value >= lim_lower && !clr_err)
      |=> ($stable(err_flag) && end_flag));

  // R9
  clear_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_end && !cap_valid) |=> !end_flag);

endmodule

// File: rtl/clk_window_monitor.sv
`timescale 1ns/1ps
module clk_window_monitor #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             ref_mode_pin,
  input  logic             ref_pin_en,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] lim_upper,
  input  logic [CNT_W-1:0] lim_lower,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             irq_end_en,
  input  logic             irq_err_en,
  input  logic             clr_end,
  input  logic             clr_err,
  output logic [CNT_W-1:0] meas_count,
  output logic             run_active,
  output logic             end_flag,
  output logic             err_flag,
  output logic             irq_end,
  output logic             irq_err
);

  logic             run_q;
  logic             edge_pulse;
  logic             cap_valid;
  logic [CNT_W-1:0] cap_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_wr) run_q <= run_wdata & ref_mode_pin & ref_pin_en;
  end

  ref_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_async  (ref_in),
    .edge_sel   (edge_sel),
    .edge_pulse (edge_pulse)
  );

  period_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .edge_pulse (edge_pulse),
    .cap_value  (cap_value),
    .cap_valid  (cap_valid)
  );

  window_check #(.CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_value (cap_value),
    .cap_valid (cap_valid),
    .lim_upper (lim_upper),
    .lim_lower (lim_lower),
    .clr_end   (clr_end),
    .clr_err   (clr_err),
    .end_flag  (end_flag),
    .err_flag  (err_flag)
  );

  assign meas_count = cap_value;
  assign run_active = run_q;
  assign irq_end    = end_flag & irq_end_en;
  assign irq_err    = err_flag & irq_err_en;

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_wr && !(ref_mode_pin && ref_pin_en)) |=> !run_active);

  // R11
  stop_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_active && $past(!run_active)) |=> $stable(meas_count));

endmodule

// File: tb/clk_window_monitor_test.sv
`timescale 1ns/1ps
module clk_window_monitor_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_in = 1'b0;
  logic         ref_mode_pin = 1'b1;
  logic         ref_pin_en = 1'b1;
  logic [1:0]   edge_sel = 2'b00;
  logic [W-1:0] lim_upper = 8'd100;
  logic [W-1:0] lim_lower = 8'd50;
  logic         run_wr = 1'b0;
  logic         run_wdata = 1'b0;
  logic         irq_end_en = 1'b0;
  logic         irq_err_en = 1'b0;
  logic         clr_end = 1'b0;
  logic         clr_err = 1'b0;
  logic [W-1:0] meas_count;
  logic         run_active, end_flag, err_flag, irq_end, irq_err;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int t_rise = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_window_monitor #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_mode_pin(ref_mode_pin),
    .ref_pin_en(ref_pin_en), .edge_sel(edge_sel), .lim_upper(lim_upper),
    .lim_lower(lim_lower), .run_wr(run_wr), .run_wdata(run_wdata),
    .irq_end_en(irq_end_en), .irq_err_en(irq_err_en), .clr_end(clr_end),
    .clr_err(clr_err), .meas_count(meas_count), .run_active(run_active),
    .end_flag(end_flag), .err_flag(err_flag), .irq_end(irq_end), .irq_err(irq_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_run(input logic v);
    run_wr = 1'b1; run_wdata = v;
    hold(1);
    run_wr = 1'b0;
    hold(1);
  endtask

  task automatic clear(input logic e, input logic r);
    clr_end = e; clr_err = r;
    hold(1);
    clr_end = 1'b0; clr_err = 1'b0;
    hold(1);
  endtask

  task automatic start_rise();
    ref_in = 1'b1; t_rise = cyc;
  endtask

  task automatic wait_since(input int n);
    while (cyc - t_rise < n) @(negedge clk);
  endtask

  task automatic period_end(input int p, input int hi);
    wait_since(hi);
    ref_in = 1'b0;
    wait_since(p);
    ref_in = 1'b1; t_rise = cyc;
    hold(6);
  endtask

  task automatic flags_are(input string tag, input int e, input int r);
    check({tag, " end_flag"}, int'(end_flag), e);
    check({tag, " err_flag"}, int'(err_flag), r);
  endtask

  task automatic idle_wave();
    repeat (3) begin
      ref_in = 1'b1; hold(40);
      ref_in = 1'b0; hold(40);
    end
    hold(6);
  endtask

  task automatic t_reset();
    check("R1 meas_count", int'(meas_count), 0);
    check("R1 run_active", int'(run_active), 0);
    flags_are("R1", 0, 0);
    check("R1 irq_end", int'(irq_end), 0);
    check("R1 irq_err", int'(irq_err), 0);
  endtask

  task automatic t_gating();
    ref_mode_pin = 1'b0;
    write_run(1'b1);
    check("R2 mode off run_active", int'(run_active), 0);
    idle_wave();
    check("R2 mode off meas_count", int'(meas_count), 0);
    check("R2 mode off end_flag", int'(end_flag), 0);
    ref_mode_pin = 1'b1; ref_pin_en = 1'b0;
    write_run(1'b1);
    check("R2 pin off run_active", int'(run_active), 0);
    idle_wave();
    check("R2 pin off meas_count", int'(meas_count), 0);
    check("R2 pin off end_flag", int'(end_flag), 0);
    ref_pin_en = 1'b1;
  endtask

  task automatic t_window();
    write_run(1'b1);
    check("R2 accepted run_active", int'(run_active), 1);
    start_rise();
    hold(6);
    check("R3 arm meas_count", int'(meas_count), 0);
    flags_are("R3 arm", 0, 0);
    period_end(80, 40);
    check("R4 period 80", int'(meas_count), 80);
    flags_are("R5 inside", 1, 0);
    check("R10 irq_end masked", int'(irq_end), 0);
    irq_end_en = 1'b1; hold(1);
    check("R10 irq_end on", int'(irq_end), 1);
    clear(1'b1, 1'b0);
    check("R9 end cleared", int'(end_flag), 0);
    check("R10 irq_end follows", int'(irq_end), 0);

    period_end(110, 60);
    check("R4 period 110", int'(meas_count), 110);
    flags_are("R6 above", 1, 1);
    check("R10 irq_err masked", int'(irq_err), 0);
    irq_err_en = 1'b1; hold(1);
    check("R10 irq_err on", int'(irq_err), 1);
    clear(1'b0, 1'b1);
    flags_are("R9 err only cleared", 1, 0);
    clear(1'b1, 1'b0);
    flags_are("R9 end cleared", 0, 0);

    period_end(30, 15);
    check("R4 period 30", int'(meas_count), 30);
    flags_are("R7 below", 1, 1);
    clear(1'b1, 1'b1);

    period_end(100, 50);
    flags_are("R5 upper inclusive", 1, 0);
    clear(1'b1, 1'b0);
    period_end(50, 25);
    flags_are("R5 lower inclusive", 1, 0);
    clear(1'b1, 1'b0);
    period_end(101, 50);
    flags_are("R6 one above", 1, 1);
    clear(1'b1, 1'b1);
    period_end(49, 25);
    flags_are("R7 one below", 1, 1);
    clear(1'b1, 1'b1);
  endtask

  task automatic t_edges();
    write_run(1'b0); edge_sel = 2'b01; write_run(1'b1);
    ref_in = 1'b0; hold(70);
    ref_in = 1'b1; hold(20);
    ref_in = 1'b0; hold(6);
    check("R8 falling period", int'(meas_count), 90);

    write_run(1'b0); edge_sel = 2'b10; write_run(1'b1);
    ref_in = 1'b1; hold(20);
    ref_in = 1'b0; hold(6);
    check("R8 both high phase", int'(meas_count), 20);
    hold(64);
    ref_in = 1'b1; hold(6);
    check("R8 both low phase", int'(meas_count), 70);

    write_run(1'b0); edge_sel = 2'b11; write_run(1'b1);
    ref_in = 1'b0; hold(30);
    ref_in = 1'b1; hold(10);
    ref_in = 1'b0; hold(6);
    check("R8 reserved ignores fall", int'(meas_count), 70);
    hold(44);
    ref_in = 1'b1; hold(6);
    check("R8 reserved acts as rising", int'(meas_count), 60);
  endtask

  task automatic t_stop();
    clear(1'b1, 1'b1);
    write_run(1'b0);
    check("R11 run_active off", int'(run_active), 0);
    ref_in = 1'b0; hold(30);
    ref_in = 1'b1; hold(30);
    ref_in = 1'b0; hold(30);
    ref_in = 1'b1; hold(6);
    check("R11 stopped meas_count", int'(meas_count), 60);
    check("R11 stopped end_flag", int'(end_flag), 0);
    write_run(1'b1);
    ref_in = 1'b0; hold(10);
    ref_in = 1'b1; hold(6);
    check("R11 rearm meas_count", int'(meas_count), 60);
    check("R11 rearm end_flag", int'(end_flag), 0);
    hold(20);
    ref_in = 1'b0; hold(49);
    ref_in = 1'b1; hold(6);
    check("R11 after rearm", int'(meas_count), 75);
  endtask

  task automatic t_saturate();
    clear(1'b1, 1'b1);
    hold(142);
    ref_in = 1'b0; hold(150);
    ref_in = 1'b1; hold(6);
    check("R12 saturated", int'(meas_count), 255);
    check("R12 err_flag", int'(err_flag), 1);
    clear(1'b1, 1'b1);
    hold(22);
    ref_in = 1'b0; hold(30);
    ref_in = 1'b1; hold(6);
    check("R12 recovers", int'(meas_count), 60);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    hold(4);
    rst_n = 1'b1;
    hold(2);
    t_reset();
    t_gating();
    t_window();
    t_edges();
    t_stop();
    t_saturate();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule